// File: doc/BRIEF.md
# Charge-Path Protection Controller

This block decides whether the charge switch of a single-cell battery pack may conduct. Its inputs are digital flags from analog comparators that sit outside the block. One flag says the cell is above its overcharge limit. One says the pack-negative node is at or above the discharge-current limit, which means a load is drawing current. One says the pack-negative node is below the charge-current limit, which means the charge current is too high. There is also a delay-bypass select, a zero-volt-charge enable and a periodic timebase tick. The single output enables the charge switch: high lets charging proceed, low blocks it.

Two faults are tracked, each on its own: overcharge and excess charge current. A fault is declared only after its condition has lasted for a set number of ticks without a break. A fault is released only when its own release condition has lasted for a separate number of ticks. A condition that drops before its count completes is ignored, and the count starts again from zero. An overcharge fault cannot be cleared just because the cell falls back under the limit: a load must also be present, which shows that the charger is gone. Delay lengths are tick counts. The defaults assume a 10 µs tick and cover a nominal timing set and a fast timing set.

Top module: `chg_guard`

## Requirements
- R1: During reset and on the first cycle after it, `chg_en` is 1 and no fault is active.
- R2: When `cell_ov` stays 1 over `OV_DET_TICKS` tick-qualified clock edges in a row, the overcharge fault is set and `chg_en` is 0 after the edge that carries the last tick.
- R3: If `cell_ov` returns to 0 before the overcharge detect count completes, `chg_en` stays 1 and the count restarts from zero, so a complete new run of `OV_DET_TICKS` ticks is needed.
- R4: An active overcharge fault releases only after `cell_ov`=0 together with `pn_load`=1 has lasted for `OV_REL_TICKS` ticks. With `cell_ov`=0 and `pn_load`=0 (charger still attached) it never releases.
- R5: When `pn_chg_excess` stays 1 for `OC_DET_TICKS` ticks, the excess-charge fault is set and `chg_en` goes to 0.
- R6: An active excess-charge fault releases only after `pn_load`=1 together with `pn_chg_excess`=0 has lasted for `OC_REL_TICKS` ticks.
- R7: With `dly_bypass`=1, any detect or release condition takes effect on the first clock edge where it is present, whether or not a tick arrives.
- R8: `zv_chg_en`=1 drives `chg_en` to 1 in the same cycle regardless of faults. Fault state is kept, so `chg_en` returns to 0 when `zv_chg_en` drops while a fault is still active.
- R9: While either fault is active, `chg_en` is 0 (unless R8 applies). It returns to 1 only after every active fault has released.
- R10: Delay counts advance only on edges where `tick`=1. Any number of tickless cycles leaves a pending detection unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase pulse, one clock wide, that advances the delay counters |
| cell_ov | input | 1 | Cell voltage above the overcharge limit |
| pn_load | input | 1 | Pack-negative node at or above the discharge-current limit (load present) |
| pn_chg_excess | input | 1 | Pack-negative node below the charge-current limit (charge current too high) |
| dly_bypass | input | 1 | 1 = every delay is skipped |
| zv_chg_en | input | 1 | Zero-volt charge enable; forces the charge switch on |
| chg_en | output | 1 | Charge switch enable, 1 = conduct |

## Verification
The hardest state to reach is one where both faults are active and they must be released one at a time. Getting there needs an overcharge hold and an excess-charge hold that overlap long enough for both counts to finish. After that, the excess-charge fault is released while the cell stays above its limit, so that the overcharge fault alone keeps the output low. Directed sequences build this state with short delay overrides. They also cover interrupted holds, tickless stretches and a charger that stays attached. A long constrained-random run then varies tick density and flag patterns against a bench model, with the flags biased toward long holds so that the delay counts actually complete.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;

    // Tick counts for a 10 us timebase
    localparam int unsigned NOM_OV_DET  = 25000; // 250 ms
    localparam int unsigned FAST_OV_DET = 100;   // 1 ms
    localparam int unsigned NOM_OV_REL  = 1600;  // 16 ms
    localparam int unsigned NOM_OC_DET  = 1600;  // 16 ms
    localparam int unsigned FAST_OC_DET = 800;   // 8 ms
    localparam int unsigned NOM_OC_REL  = 120;   // 1.2 ms

    typedef enum logic {
        FLT_CLEAR  = 1'b0,
        FLT_ACTIVE = 1'b1
    } flt_state_e;

    // Qualifying conditions for one fault channel
    typedef struct packed {
        logic det;
        logic rel;
    } flt_cond_t;

    function automatic int unsigned pick_ticks(input bit fast,
                                               input int unsigned nominal,
                                               input int unsigned quick);
        return fast ? quick : nominal;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/chg_guard_timer.sv
module chg_guard_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bypass,
    input  logic cond,
    output logic hit
);
    localparam int unsigned W = chg_guard_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Fires on the edge carrying the LIMIT-th tick of an unbroken hold
    assign hit = cond && (bypass || (tick && (cnt_q == LAST)));

    always_ff @(posedge clk) begin
        if (rst || !cond || hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/chg_guard_fault.sv
module chg_guard_fault #(
    parameter int unsigned DET_TICKS = 4,
    parameter int unsigned REL_TICKS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    bypass,
    input  chg_guard_pkg::flt_cond_t cond,
    output logic                    active
);
    import chg_guard_pkg::*;

    flt_state_e state_q;
    logic det_hit, rel_hit;
    logic det_run, rel_run;

    assign det_run = cond.det && (state_q == FLT_CLEAR);
    assign rel_run = cond.rel && (state_q == FLT_ACTIVE);

    chg_guard_timer #(.LIMIT(DET_TICKS)) det_tmr_i (
        .clk(clk), .rst(rst), .tick(tick), .bypass(bypass),
        .cond(det_run), .hit(det_hit)
    );

    chg_guard_timer #(.LIMIT(REL_TICKS)) rel_tmr_i (
        .clk(clk), .rst(rst), .tick(tick), .bypass(bypass),
        .cond(rel_run), .hit(rel_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_CLEAR;
        end else begin
            unique case (state_q)
                FLT_CLEAR:  if (det_hit) state_q <= FLT_ACTIVE;
                FLT_ACTIVE: if (rel_hit) state_q <= FLT_CLEAR;
                default:    state_q <= FLT_CLEAR;
            endcase
        end
    end

    assign active = (state_q == FLT_ACTIVE);
endmodule

// File: rtl/chg_guard.sv
module chg_guard #(
    parameter bit          FAST_VARIANT = 1'b0,
    parameter int unsigned OV_DET_TICKS = chg_guard_pkg::pick_ticks(FAST_VARIANT,
                                              chg_guard_pkg::NOM_OV_DET, chg_guard_pkg::FAST_OV_DET),
    parameter int unsigned OV_REL_TICKS = chg_guard_pkg::NOM_OV_REL,
    parameter int unsigned OC_DET_TICKS = chg_guard_pkg::pick_ticks(FAST_VARIANT,
                                              chg_guard_pkg::NOM_OC_DET, chg_guard_pkg::FAST_OC_DET),
    parameter int unsigned OC_REL_TICKS = chg_guard_pkg::NOM_OC_REL
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cell_ov,
    input  logic pn_load,
    input  logic pn_chg_excess,
    input  logic dly_bypass,
    input  logic zv_chg_en,
    output logic chg_en
);
    import chg_guard_pkg::*;

    localparam int NUM_FLT = 2;
    localparam int IDX_OV  = 0;
    localparam int IDX_OC  = 1;

    flt_cond_t        conds [NUM_FLT];
    logic [NUM_FLT-1:0] flt_act;
    logic             ov_flt, oc_flt;

    // Overcharge: release needs cell back below limit and a load present
    assign conds[IDX_OV].det = cell_ov;
    assign conds[IDX_OV].rel = !cell_ov && pn_load;
    // Excess charge: release needs charger gone and a load present
    assign conds[IDX_OC].det = pn_chg_excess;
    assign conds[IDX_OC].rel = pn_load && !pn_chg_excess;

    for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
        localparam int unsigned DT = (g == IDX_OV) ? OV_DET_TICKS : OC_DET_TICKS;
        localparam int unsigned RT = (g == IDX_OV) ? OV_REL_TICKS : OC_REL_TICKS;
        chg_guard_fault #(.DET_TICKS(DT), .REL_TICKS(RT)) flt_i (
            .clk(clk), .rst(rst), .tick(tick), .bypass(dly_bypass),
            .cond(conds[g]), .active(flt_act[g])
        );
    end

    assign ov_flt = flt_act[IDX_OV];
    assign oc_flt = flt_act[IDX_OC];
    assign chg_en = zv_chg_en || (flt_act == '0);
endmodule

// File: rtl/chg_guard_chk.sv
module chg_guard_chk (
    input logic clk,
    input logic rst,
    input logic cell_ov,
    input logic pn_load,
    input logic pn_chg_excess,
    input logic zv_chg_en,
    input logic chg_en,
    input logic ov_flt,
    input logic oc_flt
);
    assert_reset_open_R1: assert property (@(posedge clk)
        rst |=> (chg_en && !ov_flt && !oc_flt));

    assert_ov_set_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ov_flt) |-> $past(cell_ov));

    assert_ov_release_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ov_flt) |-> $past(!cell_ov && pn_load));

    assert_oc_set_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_flt) |-> $past(pn_chg_excess));

    assert_oc_release_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(oc_flt) |-> $past(pn_load && !pn_chg_excess));

    assert_zero_volt_force_R8: assert property (@(posedge clk) disable iff (rst)
        zv_chg_en |-> chg_en);

    assert_any_fault_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        ((ov_flt || oc_flt) && !zv_chg_en) |-> !chg_en);
endmodule

bind chg_guard chg_guard_chk chk_i (
    .clk(clk), .rst(rst), .cell_ov(cell_ov), .pn_load(pn_load),
    .pn_chg_excess(pn_chg_excess), .zv_chg_en(zv_chg_en), .chg_en(chg_en),
    .ov_flt(ov_flt), .oc_flt(oc_flt)
);

// File: tb/chg_guard_tb.sv
module chg_guard_tb_top;
    localparam int OVD = 6;
    localparam int OVR = 4;
    localparam int OCD = 5;
    localparam int OCR = 3;

    logic clk = 1'b0;
    logic rst, tick, cell_ov, pn_load, pn_chg_excess, dly_bypass, zv_chg_en;
    logic chg_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    bit m_ov, m_oc;
    int c_ovd, c_ovr, c_ocd, c_ocr;

    always #4 clk = ~clk;

    chg_guard #(
        .FAST_VARIANT(1'b0), .OV_DET_TICKS(OVD), .OV_REL_TICKS(OVR),
        .OC_DET_TICKS(OCD), .OC_REL_TICKS(OCR)
    ) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cell_ov(cell_ov), .pn_load(pn_load),
        .pn_chg_excess(pn_chg_excess), .dly_bypass(dly_bypass),
        .zv_chg_en(zv_chg_en), .chg_en(chg_en)
    );

    // Returns 1 when a hold of 'lim' ticks completes on this edge
    function automatic bit hold_done(input bit cond, input int lim, inout int c,
                                     input bit tk, input bit byp);
        if (!cond) begin c = 0; return 1'b0; end
        if (byp || (tk && (c + 1 >= lim))) begin c = 0; return 1'b1; end
        if (tk) c = c + 1;
        return 1'b0;
    endfunction

    function automatic bit exp_en(input bit ov, input bit oc, input bit zv);
        return zv || (!ov && !oc);
    endfunction

    task automatic model_edge();
        bit nov, noc;
        nov = m_ov; noc = m_oc;
        if (!m_ov) begin
            if (hold_done(cell_ov, OVD, c_ovd, tick, dly_bypass)) nov = 1'b1;
        end else begin
            c_ovd = 0;
            if (hold_done(!cell_ov && pn_load, OVR, c_ovr, tick, dly_bypass)) nov = 1'b0;
        end
        if (m_ov) begin end else c_ovr = 0;
        if (!m_oc) begin
            if (hold_done(pn_chg_excess, OCD, c_ocd, tick, dly_bypass)) noc = 1'b1;
        end else begin
            c_ocd = 0;
            if (hold_done(pn_load && !pn_chg_excess, OCR, c_ocr, tick, dly_bypass)) noc = 1'b0;
        end
        if (!m_oc) c_ocr = 0;
        m_ov = nov; m_oc = noc;
    endtask

    task automatic check(input string tag, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: chg_en actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Run n cycles with current inputs; compare against model each cycle
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(tag, chg_en, exp_en(m_ov, m_oc, zv_chg_en));
        end
    endtask

    task automatic set_in(input bit ov, input bit ld, input bit ce);
        cell_ov = ov; pn_load = ld; pn_chg_excess = ce;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; tick = 1'b1; dly_bypass = 1'b0; zv_chg_en = 1'b0;
        set_in(0, 0, 0);
        m_ov = 0; m_oc = 0; c_ovd = 0; c_ovr = 0; c_ocd = 0; c_ocr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", chg_en, 1'b1);
        rst = 1'b0;
        run(2, "R1");
        check("R1 after reset", chg_en, 1'b1);

        // R2: detection after full hold
        set_in(1, 0, 0);
        run(OVD - 1, "R2");
        check("R2 before expiry", chg_en, 1'b1);
        run(1, "R2");
        check("R2 at expiry", chg_en, 1'b0);

        // R4: charger kept attached -> no release
        set_in(0, 0, 0);
        run(20, "R4");
        check("R4 no release with charger", chg_en, 1'b0);
        set_in(0, 1, 0);
        run(OVR - 1, "R4");
        check("R4 release not yet", chg_en, 1'b0);
        run(1, "R4");
        check("R4 released with load", chg_en, 1'b1);

        // R3: interrupted hold restarts the count
        set_in(0, 0, 0);
        set_in(1, 0, 0); run(OVD - 2, "R3");
        set_in(0, 0, 0); run(1, "R3");
        set_in(1, 0, 0); run(OVD - 1, "R3");
        check("R3 restart not expired", chg_en, 1'b1);
        run(1, "R3");
        check("R3 full new hold", chg_en, 1'b0);
        set_in(0, 1, 0); run(OVR, "R3");
        check("R3 cleanup release", chg_en, 1'b1);

        // R10: no ticks, no progress
        tick = 1'b0; set_in(1, 0, 0);
        run(40, "R10");
        check("R10 tickless hold", chg_en, 1'b1);
        tick = 1'b1;
        run(OVD, "R10");
        check("R10 ticks resume", chg_en, 1'b0);
        set_in(0, 1, 0); run(OVR, "R10");
        check("R10 release", chg_en, 1'b1);

        // R5 / R6: excess charge current
        set_in(0, 0, 1);
        run(OCD - 1, "R5");
        check("R5 before expiry", chg_en, 1'b1);
        run(1, "R5");
        check("R5 at expiry", chg_en, 1'b0);
        set_in(0, 0, 0); run(10, "R6");
        check("R6 no release without load", chg_en, 1'b0);
        set_in(0, 1, 1); run(6, "R6");
        check("R6 no release while excess", chg_en, 1'b0);
        set_in(0, 1, 0); run(OCR - 1, "R6");
        check("R6 release not yet", chg_en, 1'b0);
        run(1, "R6");
        check("R6 released", chg_en, 1'b1);

        // R9: both faults, release one at a time
        set_in(1, 0, 1); run(OVD, "R9");
        check("R9 both set", chg_en, 1'b0);
        set_in(1, 1, 0); run(OCR + 2, "R9");
        check("R9 overcharge still holds", chg_en, 1'b0);
        set_in(0, 1, 0); run(OVR - 1, "R9");
        check("R9 last fault pending", chg_en, 1'b0);
        run(1, "R9");
        check("R9 all released", chg_en, 1'b1);

        // R7: bypass
        dly_bypass = 1'b1; tick = 1'b0;
        set_in(1, 0, 0); run(1, "R7");
        check("R7 immediate detect", chg_en, 1'b0);
        set_in(0, 1, 0); run(1, "R7");
        check("R7 immediate release", chg_en, 1'b1);
        set_in(0, 0, 1); run(1, "R7");
        check("R7 immediate excess detect", chg_en, 1'b0);

        // R8: zero-volt enable overrides but keeps the fault
        set_in(0, 0, 0);
        zv_chg_en = 1'b1; run(3, "R8");
        check("R8 forced on", chg_en, 1'b1);
        zv_chg_en = 1'b0; run(1, "R8");
        check("R8 fault retained", chg_en, 1'b0);
        set_in(0, 1, 0); run(1, "R8");
        dly_bypass = 1'b0; tick = 1'b1;

        // Random phase: covers R2, R4, R5, R6, R7, R8, R10
        for (int blk = 0; blk < 400; blk++) begin
            int len;
            set_in(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0);
            dly_bypass = ($urandom % 25) == 0;
            zv_chg_en  = ($urandom % 20) == 0;
            len = 1 + ($urandom % 12);
            for (int k = 0; k < len; k++) begin
                tick = ($urandom % 3) != 0;
                run(1, "R2,R4,R5,R6,R7,R8,R10 random");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule